// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scanner with Duty Control

This block lights up to four common-anode seven-segment digits, each with a decimal point, from a configuration held elsewhere on the chip. It enables one digit at a time and visits digits 0 through a programmed last digit in rising order. Inside each digit's time slot it keeps the digit lit for only part of the slot, as set by a 4-bit brightness value. The eight segment enables come either from a built-in hexadecimal character generator or straight from the digit's data byte.

A system-clock prescaler paces the scan. One slot is 16 sub-ticks of `SUB_DIV` clocks each. With the default divider and a 100 MHz clock, a four-digit scan repeats at about 480 Hz, inside the usual 240 to 960 Hz band. A two-bit mode input selects normal display, a forced blank, a forced all-segments-on test pattern, or the dark standby/cleared state. Every input is a plain level that is sampled each clock. There is no stream traffic, so there is no valid/ready handshake and no back-pressure.

Mode codes on `mode_i`: 00 standby or cleared, 01 normal, 10 blank, 11 all-on. Digit k's byte sits at `data_i[8k+7:8k]`. Segment bit order on `seg_o` is a, b, c, d, e, f, g in bits 0 to 6 and the decimal point in bit 7.

Top module: `seg_scanner`

## Requirements
- R1: At most one bit of `dig_en_o` is high in any cycle.
- R2: With last-digit code n on `digits_i` (0 to 3), only digits 0..n are ever enabled. Enables above n stay low.
- R3: In normal and all-on modes, each scanned digit is lit for duty*`SUB_DIV` clocks out of every scan of (n+1)*16*`SUB_DIV` clocks. A duty of 0 keeps every digit dark.
- R4: In decode mode (`decode_i`=1), a byte with bits 5..4 = 00 shows the hex glyph of bits 3..0. The glyphs are, in gfedcba form: 0=3F 1=06 2=5B 3=4F 4=66 5=6D 6=7D 7=07 8=7F 9=6F A=77 b=7C C=39 d=5E E=79 F=71. A zero byte shows the numeral 0.
- R5: In decode mode, bits 5..4 = 01 with bits 3..0 = 0000 gives a blank digit, and every other code with bits 5..4 not 00 also gives blank segments a to g.
- R6: In decode mode, bit 6 alone drives the decimal point (1 = on), and bit 7 has no effect.
- R7: In pass-through mode (`decode_i`=0), byte bits 0..7 drive `seg_o` bits 0..7 directly, with 1 = on.
- R8: In normal mode, `seg_o` is 0 in every cycle where no digit is enabled.
- R9: Blank mode (10) holds `dig_en_o` and `seg_o` at 0.
- R10: All-on mode (11) holds `seg_o` at FF while the digits keep scanning per R2 and R3.
- R11: Standby/cleared mode (00) holds both outputs at 0. On return to normal with unchanged settings, the same display comes back.
- R12: While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 standby/cleared, 01 normal, 10 blank, 11 all-on |
| duty_i | input | 4 | On-time per slot in sixteenths |
| decode_i | input | 1 | 1 = character generator, 0 = pass-through |
| digits_i | input | 2 | Index of the last scanned digit |
| data_i | input | 32 | Four digit bytes, digit k at bits 8k+7:8k |
| dig_en_o | output | 4 | One-hot digit enables (anode drive) |
| seg_o | output | 8 | Segment enables a..g, Dp |

## Verification
Both outputs are registered. A change on any input therefore reaches `dig_en_o` and `seg_o` one clock later, and the properties are written with that one-cycle delay. The scan position can sit anywhere in a slot when settings change, and a slot that has fallen out of range only wraps at its own end. For these reasons the bench waits one full four-digit scan after each change. It then observes for exactly one scan period of the new configuration. Measured that way, the per-digit on-counts of R3 do not depend on the phase at which the window starts, and each window is checked against the values the driver queued for it.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_RUN   = 2'b01,
    MODE_BLANK = 2'b10,
    MODE_ALLON = 2'b11
  } scan_mode_e;

  localparam int SUB_STEPS = 16;
  localparam int SUB_W     = $clog2(SUB_STEPS);
  localparam int SEG_W     = 8;

  // Seven-segment shapes, bit 0 = a ... bit 6 = g.
  function automatic logic [6:0] hex_glyph(input logic [3:0] v);
    logic [6:0] g;
    case (v)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h39;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/seg_scan_timer.sv
module seg_scan_timer #(
  parameter int SUB_DIV    = 3255,
  parameter int NUM_DIGITS = 4,
  localparam int DIG_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int PRE_W     = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [DIG_W-1:0]               last_i,
  output logic [DIG_W-1:0]               slot_o,
  output logic [seg_scan_pkg::SUB_W-1:0] sub_o
);
  import seg_scan_pkg::*;

  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SUB_DIV - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_STEPS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [SUB_W-1:0] sub_q;
  logic [DIG_W-1:0] slot_q;
  logic             tick;
  logic             slot_end;

  assign tick     = (pre_q == PRE_LAST);
  assign slot_end = tick && (sub_q == SUB_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (tick) begin
      sub_q <= sub_q + 1'b1;
    end
  end

  // The slot only moves at the end of a full slot, so a shrinking digit
  // count takes effect at a slot boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (slot_end) begin
      if (slot_q >= last_i) begin
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign slot_o = slot_q;
  assign sub_o  = sub_q;

endmodule

// File: rtl/seg_char_decode.sv
module seg_char_decode (
  input  logic                           decode_i,
  input  logic [seg_scan_pkg::SEG_W-1:0] byte_i,
  output logic [seg_scan_pkg::SEG_W-1:0] seg_o
);
  import seg_scan_pkg::*;

  logic [6:0] body;

  always_comb begin
    // Only the 00 group selects a glyph. The blank code and every other
    // group give dark segments.
    if (byte_i[5:4] == 2'b00) begin
      body = hex_glyph(byte_i[3:0]);
    end else begin
      body = 7'h00;
    end
    if (decode_i) begin
      seg_o = {byte_i[6], body};
    end else begin
      seg_o = byte_i;
    end
  end

endmodule

// File: rtl/seg_scanner.sv
module seg_scanner #(
  parameter int SUB_DIV    = 3255,
  parameter int NUM_DIGITS = 4,
  localparam int DIG_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int DATA_W    = NUM_DIGITS * seg_scan_pkg::SEG_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     mode_i,
  input  logic [3:0]                     duty_i,
  input  logic                           decode_i,
  input  logic [DIG_W-1:0]               digits_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic [NUM_DIGITS-1:0]          dig_en_o,
  output logic [seg_scan_pkg::SEG_W-1:0] seg_o
);
  import seg_scan_pkg::*;

  scan_mode_e             mode;
  logic [DIG_W-1:0]       slot;
  logic [SUB_W-1:0]       sub;
  logic [SEG_W-1:0]       bytes [NUM_DIGITS];
  logic [SEG_W-1:0]       cur_byte;
  logic [SEG_W-1:0]       cur_seg;
  logic                   in_range;
  logic                   scanning;
  logic                   lit;
  logic [NUM_DIGITS-1:0]  dig_d, dig_q;
  logic [SEG_W-1:0]       seg_d, seg_q;

  assign mode = scan_mode_e'(mode_i);

  seg_scan_timer #(
    .SUB_DIV   (SUB_DIV),
    .NUM_DIGITS(NUM_DIGITS)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .last_i(digits_i),
    .slot_o(slot),
    .sub_o (sub)
  );

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_unpack
    assign bytes[k] = data_i[k*SEG_W +: SEG_W];
  end

  assign cur_byte = bytes[slot];

  seg_char_decode u_dec (
    .decode_i(decode_i),
    .byte_i  (cur_byte),
    .seg_o   (cur_seg)
  );

  assign in_range = (slot <= digits_i);
  assign scanning = (mode == MODE_RUN) || (mode == MODE_ALLON);
  assign lit      = scanning && in_range && (sub < duty_i);

  always_comb begin
    dig_d = '0;
    if (lit) begin
      dig_d[slot] = 1'b1;
    end
  end

  always_comb begin
    case (mode)
      MODE_ALLON: seg_d = '1;
      MODE_RUN:   seg_d = lit ? cur_seg : '0;
      default:    seg_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig_q <= '0;
      seg_q <= '0;
    end else begin
      dig_q <= dig_d;
      seg_q <= seg_d;
    end
  end

  assign dig_en_o = dig_q;
  assign seg_o    = seg_q;

endmodule

// File: rtl/seg_scanner_chk.sv
module seg_scanner_chk #(
  parameter int NUM_DIGITS = 4,
  localparam int DIG_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            mode_i,
  input logic [3:0]            duty_i,
  input logic [DIG_W-1:0]      digits_i,
  input logic [NUM_DIGITS-1:0] dig_en_o,
  input logic [7:0]            seg_o
);

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_en_o));

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dig_en_o >> (int'($past(digits_i)) + 1)) == '0));

  p_dark_duty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == 4'd0) |=> (dig_en_o == '0));

  p_idle_segs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01) |=> ((dig_en_o != '0) || (seg_o == 8'h00)));

  p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10) |=> ((dig_en_o == '0) && (seg_o == 8'h00)));

  p_allon_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |=> (seg_o == 8'hFF));

  p_standby_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |=> ((dig_en_o == '0) && (seg_o == 8'h00)));

endmodule

bind seg_scanner seg_scanner_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_i  (mode_i),
  .duty_i  (duty_i),
  .digits_i(digits_i),
  .dig_en_o(dig_en_o),
  .seg_o   (seg_o)
);

// File: tb/seg_scanner_test.sv
module seg_scanner_test;
  localparam int DIV    = 3;
  localparam int NDIG   = 4;
  localparam int SETTLE = NDIG * 16 * DIV + 4;

  typedef struct {
    string            tag;
    int               win;
    logic [3:0][15:0] cnt;
    logic [3:0][7:0]  seg;
    logic [7:0]       idle;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [3:0]  duty_i = 4'd0;
  logic        decode_i = 1'b1;
  logic [1:0]  digits_i = 2'd3;
  logic [31:0] data_i = '0;
  logic [3:0]  dig_en_o;
  logic [7:0]  seg_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    mon_done = 1'b0;
  item_t q[$];

  always #5 clk = ~clk;

  seg_scanner #(.SUB_DIV(DIV), .NUM_DIGITS(NDIG)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .duty_i(duty_i),
    .decode_i(decode_i), .digits_i(digits_i), .data_i(data_i),
    .dig_en_o(dig_en_o), .seg_o(seg_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_seg(input logic [7:0] b, input logic dec);
    logic [6:0] g;
    if (!dec) return b;
    if (b[5:4] != 2'b00) g = 7'h00;
    else begin
      case (b[3:0])
        4'h0: g = 7'h3F; 4'h1: g = 7'h06; 4'h2: g = 7'h5B; 4'h3: g = 7'h4F;
        4'h4: g = 7'h66; 4'h5: g = 7'h6D; 4'h6: g = 7'h7D; 4'h7: g = 7'h07;
        4'h8: g = 7'h7F; 4'h9: g = 7'h6F; 4'hA: g = 7'h77; 4'hB: g = 7'h7C;
        4'hC: g = 7'h39; 4'hD: g = 7'h5E; 4'hE: g = 7'h79; default: g = 7'h71;
      endcase
    end
    return {b[6], g};
  endfunction

  // Driver: apply settings, let the scan settle, then queue the expectation.
  task automatic run_case(input string tag, input logic [1:0] m, input logic [3:0] d,
                          input logic dec, input logic [1:0] n, input logic [31:0] data);
    item_t it;
    bit scan;
    @(negedge clk);
    mode_i = m; duty_i = d; decode_i = dec; digits_i = n; data_i = data;
    repeat (SETTLE) @(negedge clk);
    scan = (m == 2'b01) || (m == 2'b11);
    it.tag  = tag;
    it.win  = (int'(n) + 1) * 16 * DIV;
    it.idle = (m == 2'b11) ? 8'hFF : 8'h00;
    for (int k = 0; k < NDIG; k++) begin
      it.cnt[k] = (scan && k <= int'(n)) ? 16'(int'(d) * DIV) : 16'd0;
      it.seg[k] = (m == 2'b11) ? 8'hFF : ref_seg(data[8*k +: 8], dec);
    end
    mon_done = 1'b0;
    q.push_back(it);
    wait (mon_done);
  endtask

  // Monitor: pop one expectation, observe one scan period, compare.
  initial begin
    forever begin
      item_t it;
      int cnt [NDIG];
      int bad_seg [NDIG];
      logic [7:0] seen [NDIG];
      int multi, bad_idle;
      logic [7:0] idle_seen;
      wait (q.size() > 0);
      it = q.pop_front();
      multi = 0; bad_idle = 0; idle_seen = it.idle;
      for (int k = 0; k < NDIG; k++) begin
        cnt[k] = 0; bad_seg[k] = 0; seen[k] = it.seg[k];
      end
      for (int c = 0; c < it.win; c++) begin
        @(negedge clk);
        if ($countones(dig_en_o) > 1) multi++;
        if (dig_en_o == 4'b0000) begin
          if (seg_o != it.idle) begin bad_idle++; idle_seen = seg_o; end
        end
        for (int k = 0; k < NDIG; k++) begin
          if (dig_en_o == 4'(1 << k)) begin
            cnt[k]++;
            if (seg_o != it.seg[k]) begin bad_seg[k]++; seen[k] = seg_o; end
          end
        end
      end
      check({it.tag, " R1 one digit at a time"}, multi, 0);
      for (int k = 0; k < NDIG; k++) begin
        check($sformatf("%s R2/R3 on-count digit %0d", it.tag, k), cnt[k], int'(it.cnt[k]));
        if (it.cnt[k] != 0)
          check($sformatf("%s segments digit %0d", it.tag, k), int'(seen[k]), int'(it.seg[k]));
      end
      check({it.tag, " R8 segments while no digit lit"}, int'(idle_seen), int'(it.idle));
      mon_done = 1'b1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    mode_i = 2'b01; duty_i = 4'd15;
    repeat (5) @(negedge clk);
    check("R12 reset digits", int'(dig_en_o), 0);
    check("R12 reset segments", int'(seg_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R4: zero bytes in decode mode show the numeral 0
    run_case("R4 default zero", 2'b01, 4'd15, 1'b1, 2'd3, 32'h0000_0000);
    // R4: letters A b C d at half duty
    run_case("R4 letters", 2'b01, 4'd8, 1'b1, 2'd3, 32'h0D0C_0B0A);
    run_case("R4 digits 9 5 7 E", 2'b01, 4'd3, 1'b1, 2'd3, 32'h0E07_0509);
    // R2: two digits scanned, upper two dark
    run_case("R2 two digits", 2'b01, 4'd10, 1'b1, 2'd1, 32'h0403_0201);
    run_case("R2 one digit", 2'b01, 4'd15, 1'b1, 2'd0, 32'h0000_0006);
    // R3: duty 0 keeps everything dark
    run_case("R3 duty zero", 2'b01, 4'd0, 1'b1, 2'd3, 32'h0302_0100);
    run_case("R3 duty one", 2'b01, 4'd1, 1'b1, 2'd2, 32'h0F0F_0F0F);
    // R5 blank and undefined codes, R6 decimal point and ignored bit 7
    run_case("R5 R6 blank dp", 2'b01, 4'd12, 1'b1, 2'd3, 32'hC750_2510);
    // R7 pass-through bit mapping
    run_case("R7 pass", 2'b01, 4'd9, 1'b0, 2'd3, 32'hFF5A_8001);
    // R9 blank mode
    run_case("R9 blank", 2'b10, 4'd15, 1'b1, 2'd3, 32'h0D0C_0B0A);
    // R10 all-on keeps scanning at duty
    run_case("R10 all-on", 2'b11, 4'd5, 1'b1, 2'd2, 32'h0000_0000);
    // R11 standby dark, then the same display returns
    run_case("R11 standby", 2'b00, 4'd7, 1'b1, 2'd3, 32'h4D4C_4B4A);
    run_case("R11 resume", 2'b01, 4'd7, 1'b1, 2'd3, 32'h4D4C_4B4A);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule